// File: doc/BRIEF.md
# Synchronous Clock Stop Controller

This block gates a set of clock outputs taken from two free-running source clocks, a CPU clock and a PCI clock. An output can be stopped in three ways. Each output has its own enable bit in a control register. An active-low PCI stop input halts the gated PCI outputs. An active-low power-down input parks every output low. One PCI output is free-running: the PCI stop input never affects it, although its enable bit and power-down still do.

Each output is the source clock ANDed with an enable. The enable is registered on the falling edge of the source clock, so it can change only while the clock is low. Every high phase on an output is therefore full length. The stop and power-down inputs cross into each clock domain through two-flop synchronizers. A parallel write port stands in for the serial control bus that would load the enable register in a real system.

Top module: `clk_stop_ctrl`

## Requirements
- R1: After reset, every enable bit is set and neither the stop state nor the power-down state is active. Every output then follows its source clock.
- R2: While `pci_stop_n` is low, the gated PCI outputs are held low, starting at the third PCI rising edge after the input falls. The CPU outputs keep running.
- R3: `pci_free_out` keeps running while `pci_stop_n` is low.
- R4: After `pci_stop_n` returns high, the gated PCI outputs carry a full pulse on the third PCI rising edge and on every rising edge after it.
- R5: A CPU rising edge with `cfg_wr` high loads `cfg_wdata` into the enable register. Bits [N_CPU-1:0] enable the CPU outputs, the next N_PCI bits enable the gated PCI outputs, and the top bit enables `pci_free_out`. A cleared bit holds its output low. `cfg_wdata` has no effect while `cfg_wr` is low.
- R6: No output ever produces a high phase shorter than half its source clock period. Each output's enable changes only while its source clock is low.
- R7: Power-down is entered only after `pwr_down_n`, once synchronized, is seen low on two consecutive CPU rising edges. A low lasting one CPU cycle is ignored.
- R8: Once power-down is entered, the CPU outputs are low from the fifth CPU rising edge after `pwr_down_n` falls. The PCI outputs and the free-running PCI output are also held low.
- R9: Power-down is left only after two consecutive high samples, so a one-cycle high pulse is ignored. When it is left, the enabled CPU outputs resume on the fifth CPU rising edge. Outputs whose enable bit is cleared stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Free-running CPU source clock; also clocks the enable register and power-down detection |
| pci_clk | input | 1 | Free-running PCI source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pci_stop_n | input | 1 | Active-low stop for the gated PCI outputs |
| pwr_down_n | input | 1 | Active-low power-down request |
| cfg_wr | input | 1 | Write strobe for the enable register |
| cfg_wdata | input | N_CPU+N_PCI+1 | Enable bits to load |
| cpu_clk_out | output | N_CPU | Gated CPU clocks |
| pci_clk_out | output | N_PCI | Gated PCI clocks, subject to PCI stop |
| pci_free_out | output | 1 | PCI clock that ignores PCI stop |

## Verification
The hardest case to reach is a power-down request that is sampled low on exactly one CPU rising edge and must be rejected. The bench gets there by changing `pwr_down_n` just after a falling edge of the CPU clock and restoring it just after the next falling edge, so exactly one rising edge sees the low. The same timing gives a one-cycle high pulse during power-down, which must not end it. A second hard case is leaving power-down with an enable bit that was cleared during power-down, which shows that the register keeps the output stopped. Running in parallel with every scenario, a monitor times every high phase on every output to catch any truncated pulse.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;

    // State of the power-down detector in the CPU clock domain.
    typedef struct packed {
        logic prev;   // synchronized request seen at the previous edge
        logic pd;     // power-down currently in force
    } pd_state_t;

endpackage

// File: rtl/cs_sync.sv
// Two-flop synchronizer for a vector of independent bits.
module cs_sync #(
    parameter int               WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= RST_VAL;
            st_q.s2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.s2;
endmodule

// File: rtl/cs_gate_cell.sv
// Glitch-free clock gates: enables are captured on the falling edge of the
// source clock so an output high phase is always complete.
module cs_gate_cell #(
    parameter int WIDTH = 1
) (
    input  logic             src_clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] run,
    output logic [WIDTH-1:0] en,
    output logic [WIDTH-1:0] clk_out
);
    logic [WIDTH-1:0] en_d, en_q;

    always_comb begin
        en_d = run;
    end

    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '1;
        end else begin
            en_q <= en_d;
        end
    end

    assign en      = en_q;
    assign clk_out = {WIDTH{src_clk}} & en_q;
endmodule

// File: rtl/cs_pd_detect.sv
// Power-down entry/exit: two consecutive equal samples are needed to switch.
module cs_pd_detect
    import clk_stop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pd_n_sync,
    output logic pd_active
);
    pd_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = pd_n_sync;
        if (!pd_n_sync && !st_q.prev) begin
            st_d.pd = 1'b1;
        end else if (pd_n_sync && st_q.prev) begin
            st_d.pd = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= 1'b1;
            st_q.pd   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pd_active = st_q.pd;
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
    import clk_stop_pkg::*;
#(
    parameter int N_CPU = 2,
    parameter int N_PCI = 6
) (
    input  logic                   cpu_clk,
    input  logic                   pci_clk,
    input  logic                   rst_n,
    input  logic                   pci_stop_n,
    input  logic                   pwr_down_n,
    input  logic                   cfg_wr,
    input  logic [N_CPU+N_PCI:0]   cfg_wdata,
    output logic [N_CPU-1:0]       cpu_clk_out,
    output logic [N_PCI-1:0]       pci_clk_out,
    output logic                   pci_free_out
);
    localparam int EN_W   = N_CPU + N_PCI + 1;
    localparam int PCI_EW = N_PCI + 1;          // gated PCI bits plus free bit
    localparam int XW     = PCI_EW + 2;         // crossing width into PCI domain

    // ---------------- CPU domain: enable register ----------------
    logic [EN_W-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) begin
            cfg_d = cfg_wdata;
        end
    end

    always_ff @(posedge cpu_clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // ---------------- CPU domain: power-down recognition ----------------
    logic pd_n_s;
    logic pd_cpu;

    cs_sync #(.WIDTH(1), .RST_VAL(1'b1)) u_pd_sync (
        .clk   (cpu_clk),
        .rst_n (rst_n),
        .d     (pwr_down_n),
        .q     (pd_n_s)
    );

    cs_pd_detect u_pd_det (
        .clk       (cpu_clk),
        .rst_n     (rst_n),
        .pd_n_sync (pd_n_s),
        .pd_active (pd_cpu)
    );

    // ---------------- CPU outputs ----------------
    logic [N_CPU-1:0] cpu_run;
    logic [N_CPU-1:0] cpu_en;

    always_comb begin
        cpu_run = cfg_q[N_CPU-1:0] & {N_CPU{~pd_cpu}};
    end

    cs_gate_cell #(.WIDTH(N_CPU)) u_cpu_gate (
        .src_clk (cpu_clk),
        .rst_n   (rst_n),
        .run     (cpu_run),
        .en      (cpu_en),
        .clk_out (cpu_clk_out)
    );

    // ---------------- Crossing into the PCI domain ----------------
    logic [XW-1:0]     x_in, x_out;
    logic [PCI_EW-1:0] cfg_pci_s;
    logic              stop_pci;
    logic              pd_pci;
    logic              cfg_free_s;

    always_comb begin
        x_in = {pci_stop_n, pd_cpu, cfg_q[EN_W-1:N_CPU]};
    end

    cs_sync #(.WIDTH(XW), .RST_VAL({1'b1, 1'b0, {PCI_EW{1'b1}}})) u_pci_sync (
        .clk   (pci_clk),
        .rst_n (rst_n),
        .d     (x_in),
        .q     (x_out)
    );

    always_comb begin
        stop_pci   = ~x_out[XW-1];
        pd_pci     = x_out[XW-2];
        cfg_pci_s  = x_out[PCI_EW-1:0];
        cfg_free_s = cfg_pci_s[N_PCI];
    end

    // ---------------- PCI outputs ----------------
    logic [PCI_EW-1:0] pci_run;
    logic [PCI_EW-1:0] pci_en;
    logic [PCI_EW-1:0] pci_gated;

    generate
        for (genvar i = 0; i < PCI_EW; i++) begin : g_pci_run
            if (i < N_PCI) begin : g_stoppable
                assign pci_run[i] = cfg_pci_s[i] & ~pd_pci & ~stop_pci;
            end else begin : g_free
                assign pci_run[i] = cfg_free_s & ~pd_pci;
            end
        end
    endgenerate

    cs_gate_cell #(.WIDTH(PCI_EW)) u_pci_gate (
        .src_clk (pci_clk),
        .rst_n   (rst_n),
        .run     (pci_run),
        .en      (pci_en),
        .clk_out (pci_gated)
    );

    assign pci_clk_out  = pci_gated[N_PCI-1:0];
    assign pci_free_out = pci_gated[N_PCI];
endmodule

// File: rtl/clk_stop_ctrl_chk.sv
module clk_stop_ctrl_chk #(
    parameter int N_CPU = 2,
    parameter int N_PCI = 6
) (
    input logic             cpu_clk,
    input logic             pci_clk,
    input logic             rst_n,
    input logic             pd_n_s,
    input logic             pd_cpu,
    input logic             pd_pci,
    input logic             stop_pci,
    input logic             cfg_free_s,
    input logic [N_CPU-1:0] cpu_en,
    input logic [N_PCI:0]   pci_en,
    input logic [N_CPU-1:0] cpu_clk_out,
    input logic [N_PCI-1:0] pci_clk_out,
    input logic             pci_free_out
);
    AST_PD_ENTRY_TWO_LOWS: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        $rose(pd_cpu) |-> (!$past(pd_n_s) && !$past(pd_n_s, 2))); // R7

    AST_PD_EXIT_TWO_HIGHS: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        $fell(pd_cpu) |-> ($past(pd_n_s) && $past(pd_n_s, 2))); // R9

    AST_PD_CPU_PARKED: assert property (@(negedge cpu_clk) disable iff (!rst_n)
        $past(pd_cpu) |-> (cpu_clk_out == '0)); // R8

    AST_PD_PCI_PARKED: assert property (@(negedge pci_clk) disable iff (!rst_n)
        $past(pd_pci) |-> (pci_clk_out == '0 && !pci_free_out)); // R8

    AST_STOP_PCI_PARKED: assert property (@(negedge pci_clk) disable iff (!rst_n)
        $past(stop_pci) |-> (pci_clk_out == '0)); // R2

    AST_FREE_IGNORES_STOP: assert property (@(negedge pci_clk) disable iff (!rst_n)
        ($past(stop_pci) && !$past(pd_pci) && $past(cfg_free_s)) |-> pci_free_out); // R3

    always @(cpu_en) begin
        if (rst_n) begin
            AST_CPU_EN_IN_LOW: assert (cpu_clk == 1'b0); // R6
        end
    end

    always @(pci_en) begin
        if (rst_n) begin
            AST_PCI_EN_IN_LOW: assert (pci_clk == 1'b0); // R6
        end
    end
endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(.N_CPU(N_CPU), .N_PCI(N_PCI)) u_chk (
    .cpu_clk      (cpu_clk),
    .pci_clk      (pci_clk),
    .rst_n        (rst_n),
    .pd_n_s       (pd_n_s),
    .pd_cpu       (pd_cpu),
    .pd_pci       (pd_pci),
    .stop_pci     (stop_pci),
    .cfg_free_s   (cfg_free_s),
    .cpu_en       (cpu_en),
    .pci_en       (pci_en),
    .cpu_clk_out  (cpu_clk_out),
    .pci_clk_out  (pci_clk_out),
    .pci_free_out (pci_free_out)
);

// File: tb/clk_stop_ctrl_test.sv
module clk_stop_ctrl_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int  NC = 2;
    localparam int  NP = 6;
    localparam int  EW = NC + NP + 1;
    localparam real CPU_HALF = 2.5;
    localparam real PCI_HALF = 7.0;

    logic          cpu_clk    = 1'b0;
    logic          pci_clk    = 1'b0;
    logic          rst_n      = 1'b0;
    logic          pci_stop_n = 1'b1;
    logic          pwr_down_n = 1'b1;
    logic          cfg_wr     = 1'b0;
    logic [EW-1:0] cfg_wdata  = '0;
    logic [NC-1:0] cpu_clk_out;
    logic [NP-1:0] pci_clk_out;
    logic          pci_free_out;

    clk_stop_ctrl #(.N_CPU(NC), .N_PCI(NP)) uut (
        .cpu_clk      (cpu_clk),
        .pci_clk      (pci_clk),
        .rst_n        (rst_n),
        .pci_stop_n   (pci_stop_n),
        .pwr_down_n   (pwr_down_n),
        .cfg_wr       (cfg_wr),
        .cfg_wdata    (cfg_wdata),
        .cpu_clk_out  (cpu_clk_out),
        .pci_clk_out  (pci_clk_out),
        .pci_free_out (pci_free_out)
    );

    always #(CPU_HALF) cpu_clk = ~cpu_clk;
    always #(PCI_HALF) pci_clk = ~pci_clk;

    int total = 0;
    int bad   = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---- high-phase width monitor (R6) ----
    logic [EW-1:0] mon_prev = '0;
    real           rise_t [EW];
    bit            have_rise [EW];
    int            trunc  = 0;
    int            pulses = 0;

    always @(cpu_clk_out or pci_clk_out or pci_free_out) begin
        logic [EW-1:0] now;
        real           w;
        real           half;
        now = {pci_free_out, pci_clk_out, cpu_clk_out};
        for (int i = 0; i < EW; i++) begin
            if (now[i] === 1'b1 && mon_prev[i] !== 1'b1) begin
                rise_t[i]    = $realtime;
                have_rise[i] = 1'b1;
            end else if (now[i] === 1'b0 && mon_prev[i] === 1'b1 && have_rise[i]) begin
                half = (i < NC) ? CPU_HALF : PCI_HALF;
                w    = $realtime - rise_t[i];
                pulses++;
                if (w > half + 0.01 || w < half - 0.01) trunc++;
            end
        end
        mon_prev = now;
    end

    // ---- sampling helpers: look mid high phase after each rising edge ----
    task automatic sample_cpu(input int n, output logic [NC-1:0] all1,
                              output logic [NC-1:0] any1);
        all1 = '1;
        any1 = '0;
        for (int k = 0; k < n; k++) begin
            @(posedge cpu_clk);
            #1;
            all1 &= cpu_clk_out;
            any1 |= cpu_clk_out;
        end
    endtask

    task automatic sample_pci(input int n, output logic [NP:0] all1,
                              output logic [NP:0] any1);
        all1 = '1;
        any1 = '0;
        for (int k = 0; k < n; k++) begin
            @(posedge pci_clk);
            #1;
            all1 &= {pci_free_out, pci_clk_out};
            any1 |= {pci_free_out, pci_clk_out};
        end
    endtask

    task automatic write_cfg(input logic [EW-1:0] val);
        @(negedge cpu_clk);
        #1;
        cfg_wr    = 1'b1;
        cfg_wdata = val;
        @(negedge cpu_clk);
        #1;
        cfg_wr = 1'b0;
    endtask

    // ---- scenarios ----
    task automatic t_reset();
        logic [NC-1:0] ca, co;
        logic [NP:0]   pa, po;
        sample_cpu(8, ca, co);
        check(ca == '1, "R1", "cpu outputs run after reset", 32'(ca), 32'(2'b11));
        sample_pci(6, pa, po);
        check(pa == '1, "R1", "pci outputs run after reset", 32'(pa), 32'h7f);
    endtask

    task automatic t_cfg();
        logic [NC-1:0] ca, co;
        logic [NP:0]   pa, po;
        write_cfg({1'b0, 6'b111011, 2'b10});
        repeat (6) @(posedge pci_clk);
        sample_cpu(10, ca, co);
        check(ca == 2'b10 && co == 2'b10, "R5", "cpu bit0 disabled",
              32'({ca, co}), 32'({2'b10, 2'b10}));
        sample_pci(8, pa, po);
        check(pa == 7'b0111011 && po == 7'b0111011, "R5", "pci bit2 and free disabled",
              32'({pa, po}), 32'({7'b0111011, 7'b0111011}));
        write_cfg('1);
        repeat (6) @(posedge pci_clk);
        @(negedge cpu_clk);
        #1;
        cfg_wdata = '0;   // strobe stays low: must be ignored
        repeat (6) @(posedge pci_clk);
        sample_cpu(10, ca, co);
        check(ca == '1, "R5", "cpu data ignored without strobe", 32'(ca), 32'(2'b11));
        sample_pci(8, pa, po);
        check(pa == '1, "R5", "pci data ignored without strobe", 32'(pa), 32'h7f);
    endtask

    task automatic t_pci_stop();
        logic [NC-1:0] ca, co;
        logic [NP:0]   pa, po;
        @(negedge pci_clk);
        #1;
        pci_stop_n = 1'b0;
        repeat (2) @(posedge pci_clk);
        sample_pci(8, pa, po);   // starts at the third rising edge
        check(po[NP-1:0] == '0, "R2", "gated pci held low", 32'(po[NP-1:0]), 32'h0);
        check(pa[NP] == 1'b1, "R3", "free pci keeps running", 32'(pa[NP]), 32'h1);
        sample_cpu(10, ca, co);
        check(ca == '1, "R2", "cpu unaffected by pci stop", 32'(ca), 32'(2'b11));
        @(negedge pci_clk);
        #1;
        pci_stop_n = 1'b1;
        repeat (2) @(posedge pci_clk);
        sample_pci(8, pa, po);
        check(pa == '1, "R4", "pci resume from third edge", 32'(pa), 32'h7f);
    endtask

    task automatic t_pd_glitch();
        logic [NC-1:0] ca, co;
        logic [NP:0]   pa, po;
        @(negedge cpu_clk);
        #1;
        pwr_down_n = 1'b0;
        @(negedge cpu_clk);
        #1;
        pwr_down_n = 1'b1;
        sample_cpu(12, ca, co);
        check(ca == '1, "R7", "one-cycle low ignored (cpu)", 32'(ca), 32'(2'b11));
        sample_pci(6, pa, po);
        check(pa == '1, "R7", "one-cycle low ignored (pci)", 32'(pa), 32'h7f);
    endtask

    task automatic t_pd();
        logic [NC-1:0] ca, co;
        logic [NP:0]   pa, po;
        @(negedge cpu_clk);
        #1;
        pwr_down_n = 1'b0;
        repeat (4) @(posedge cpu_clk);
        sample_cpu(10, ca, co);   // starts at the fifth rising edge
        check(co == '0, "R8", "cpu parked from fifth edge", 32'(co), 32'h0);
        repeat (2) @(posedge pci_clk);
        sample_pci(6, pa, po);
        check(po == '0, "R8", "pci and free parked", 32'(po), 32'h0);
        // one-cycle high pulse must not end power-down
        @(negedge cpu_clk);
        #1;
        pwr_down_n = 1'b1;
        @(negedge cpu_clk);
        #1;
        pwr_down_n = 1'b0;
        sample_cpu(10, ca, co);
        check(co == '0, "R9", "one-cycle high ignored", 32'(co), 32'h0);
        // disable cpu bit1 while powered down, then leave power-down
        write_cfg({1'b1, 6'b111111, 2'b01});
        @(negedge cpu_clk);
        #1;
        pwr_down_n = 1'b1;
        repeat (4) @(posedge cpu_clk);
        sample_cpu(10, ca, co);
        check(ca == 2'b01 && co == 2'b01, "R9", "cpu resumes, disabled stays low",
              32'({ca, co}), 32'({2'b01, 2'b01}));
        repeat (3) @(posedge pci_clk);
        sample_pci(6, pa, po);
        check(pa == '1, "R9", "pci resumes after exit", 32'(pa), 32'h7f);
        write_cfg('1);
        repeat (4) @(posedge cpu_clk);
        sample_cpu(6, ca, co);
        check(ca == '1, "R5", "cpu bit1 re-enabled", 32'(ca), 32'(2'b11));
    endtask

    initial begin
        repeat (4) @(posedge cpu_clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_cfg();
        t_pci_stop();
        t_pd_glitch();
        t_pd();
        check(trunc == 0, "R6", "truncated high phases", 32'(trunc), 32'h0);
        check(pulses > 100, "R6", "high phases observed", 32'(pulses), 32'd101);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule